// File: doc/BRIEF.md
# SPI Master with Register Interface

This block is a serial peripheral interface master that software drives through three 32-bit registers: a control and status word at offset 0x0, a data port at offset 0x4 and an interrupt-acknowledge port at offset 0x8. Writing the data port queues a word for transmission. Reading it returns the oldest received word. The engine shifts each word out MSB first on a serial clock derived from the module clock, and it captures the input line into a receive word at the same time.

Word length, clock rate, clock polarity and phase, the idle level of the output line and the queueing mode are all control fields. The queueing mode sets how deep each direction is and whether a full side stalls the engine or is overwritten. A sticky completion flag, with its own mask, drives the interrupt output. Turning the engine off lets queued words drain before the queues, the flag and the read value are cleared.

Top module: `spi_reg_master`

## Requirements
- R1: After reset the control word reads 0x00A30000. In that word, bit 11 = transmit queue full, 12 = synchronised input line, 13 = completion flag, 19 = busy, 21 = receive queue empty, 22 = receive queue full, 23 = transmit queue empty. Bits 11-13, 19 and 21-23 ignore writes.
- R2: Bits [9:8] select the word length: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 9 bits. Words go out MSB first. A data read returns the received word right-aligned, and the bits above the word length keep the value of the previous data read. A read with the receive queue empty returns that previous value and changes nothing.
- R3: In 9-bit mode, control bit 20 is shifted out first, followed by data bits [7:0]. The received word occupies read bits [8:0].
- R4: Bits [4:3] set the serial clock period in module clocks: 0 = 8, 1 = 4, 2 = 2, 3 = 14. Busy stays high for exactly (word length × period) clocks per word.
- R5: The serial clock idles at the level of bit 2 and makes 2 transitions per bit. With bit 1 = 0 the input is sampled on the first edge of each bit; with bit 1 = 1 it is sampled on the second edge.
- R6: The completion flag sets at the end of every word and stays set until any write to offset 0x8. Offset 0x8 reads 0. The interrupt output equals the flag AND bit 14.
- R7: In queue mode 0 (bits [17:16]) each direction holds 4 words, first in first out. A data write while the transmit queue is full is dropped.
- R8: When the receive queue is full and receive flow control applies, no new word starts. Busy reads 0 while transmit data stays queued, and shifting resumes after a data read.
- R9: Mode 1 gives the transmit side one entry, and a write to it while full replaces the entry. Mode 2 gives the receive side one entry, and a new word overwrites it. Mode 3 gives both sides one entry, and both use flow control. Mode 3 is the reset mode.
- R10: The data output sits at the level of bit 5 while idle. With bit 10 set it sits at that level always, including during a transfer.
- R11: With bit 0 clear the engine still sends every word already queued. Once idle with an empty transmit queue it clears both queues, the completion flag and the read value. Data writes while it is off are dropped.
- R12: Bit 7 set has the same effect as bit 0 clear.
- R13: Status bit 12 follows the data input delayed by two module clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register byte offset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive queue at offset 0x4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current offset |
| irq | output | 1 | Masked completion interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench loops the output line back to the input and goes after cycle-exact busy length and clock-edge counts under every divider, polarity and phase. A divider table with the wrong entries, or an edge handled one half-period off, changes those counts or corrupts the looped-back word. It fills the receive side to check the stall and the full-write drop in each queue mode: a design without the stall would overwrite unread words, and one without the drop would send an extra word. The 9-bit lead bit, retention of the upper read bits, the drain-then-clear sequence on disable and the two-clock input delay are also targeted. These catch a lost lead bit, read bits that are zeroed instead of kept, an engine that stops mid-queue, and a status bit that is off by one clock.

// File: rtl/spi_reg_master.sv
module spi_reg_master #(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam int CW = PW + 1;
  localparam logic [31:0] CTRL_WMASK = 32'h0013_47BF;
  localparam logic [31:0] CTRL_INIT  = 32'h0003_0000;

  logic [31:0] ctrl, last_rd, sh, rsh, status, rd_view;
  logic [31:0] tx_mem [FIFO_DEPTH];
  logic [31:0] rx_mem [FIFO_DEPTH];
  logic [PW-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_lim, rx_lim;
  logic busy, ph, int_flag;
  logic [2:0] hc, half;
  logic [5:0] bitc, nbits;
  logic [1:0] msync;

  wire [1:0] mode = ctrl[17:16];
  wire [1:0] ws   = ctrl[9:8];
  wire on      = ctrl[0] & ~ctrl[7];
  wire tx_over = (mode == 2'd1);
  wire rx_over = (mode == 2'd2);

  assign tx_lim = (mode == 2'd0 || mode == 2'd2) ? CW'(FIFO_DEPTH) : CW'(1);
  assign rx_lim = (mode == 2'd0 || mode == 2'd1) ? CW'(FIFO_DEPTH) : CW'(1);

  always_comb begin
    case (ws)
      2'd0: nbits = 6'd8;
      2'd1: nbits = 6'd16;
      2'd2: nbits = 6'd32;
      default: nbits = 6'd9;
    endcase
    case (ctrl[4:3])
      2'd0: half = 3'd4;
      2'd1: half = 3'd2;
      2'd2: half = 3'd1;
      default: half = 3'd7;
    endcase
  end

  wire tx_full  = tx_cnt >= tx_lim;
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt >= rx_lim;
  wire rx_empty = rx_cnt == '0;

  wire wr_data = wr_en && addr == 4'h4;
  wire wr_clr  = wr_en && addr == 4'h8;
  wire rd_data = rd_en && addr == 4'h4 && !rx_empty;

  wire stall    = rx_full && !rx_over;
  wire start    = !busy && !tx_empty && !stall;
  wire half_end = busy && hc == half - 3'd1;
  wire done     = half_end && ph && bitc == nbits - 6'd1;
  wire flush    = !on && !busy && tx_empty;

  wire tx_norm = wr_data && on && (!tx_full || start);
  wire tx_ovw  = wr_data && on && tx_full && !start && tx_over;
  wire rx_norm = done && (!rx_full || rd_data);
  wire rx_ovw  = done && rx_full && !rd_data && rx_over;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [1:0] w);
    case (w)
      2'd0: merge = {old[31:8], nw[7:0]};
      2'd1: merge = {old[31:16], nw[15:0]};
      2'd2: merge = nw;
      default: merge = {old[31:9], nw[8:0]};
    endcase
  endfunction

  function automatic logic [31:0] align(input logic [31:0] d, input logic [1:0] w,
                                        input logic lead);
    case (w)
      2'd0: align = {d[7:0], 24'b0};
      2'd1: align = {d[15:0], 16'b0};
      2'd2: align = d;
      default: align = {lead, d[7:0], 23'b0};
    endcase
  endfunction

  assign rd_view = rx_empty ? last_rd : merge(last_rd, rx_mem[rx_rp], ws);

  always_comb begin
    status = '0;
    status[11] = tx_full;
    status[12] = msync[1];
    status[13] = int_flag;
    status[19] = busy;
    status[21] = rx_empty;
    status[22] = rx_full;
    status[23] = tx_empty;
    case (addr)
      4'h0: rdata = ctrl | status;
      4'h4: rdata = rd_view;
      default: rdata = '0;
    endcase
  end

  assign irq  = int_flag & ctrl[14];
  assign sclk = busy ? (ctrl[2] ^ ctrl[1] ^ ph) : ctrl[2];
  assign mosi = (ctrl[10] || !busy) ? ctrl[5] : sh[31];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl <= CTRL_INIT;
    else if (wr_en && addr == 4'h0) ctrl <= wdata & CTRL_WMASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) msync <= '0;
    else msync <= {msync[0], miso};

  always_ff @(posedge clk) begin
    if (tx_norm || tx_ovw) tx_mem[tx_norm ? tx_wp : tx_rp] <= wdata;
    if (rx_norm || rx_ovw) rx_mem[rx_norm ? rx_wp : rx_rp] <= rsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
      int_flag <= 1'b0; last_rd <= '0;
    end else if (flush) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
      int_flag <= 1'b0; last_rd <= '0;
    end else begin
      if (tx_norm) tx_wp <= tx_wp + 1'b1;
      if (start)   tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_norm) - CW'(start);
      if (rx_norm) rx_wp <= rx_wp + 1'b1;
      if (rd_data) begin
        rx_rp   <= rx_rp + 1'b1;
        last_rd <= rd_view;
      end
      rx_cnt <= rx_cnt + CW'(rx_norm) - CW'(rd_data);
      if (done) int_flag <= 1'b1;
      else if (wr_clr) int_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ph <= 1'b0; hc <= '0; bitc <= '0; sh <= '0; rsh <= '0;
    end else if (start) begin
      busy <= 1'b1; ph <= 1'b0; hc <= '0; bitc <= '0;
      sh <= align(tx_mem[tx_rp], ws, ctrl[20]);
    end else if (busy) begin
      if (half_end) begin
        hc <= '0;
        ph <= ~ph;
        if (!ph) rsh <= {rsh[30:0], miso};
        else begin
          sh   <= sh << 1;
          bitc <= bitc + 6'd1;
          if (done) busy <= 1'b0;
        end
      end else hc <= hc + 3'd1;
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && on && tx_full && !start) |=> tx_cnt == $past(tx_cnt)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (int_flag && !wr_clr && !flush) |=> int_flag); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stall) |=> !busy); // R8
  AST_DRAIN_GOES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !on && !done) |=> busy); // R11
  AST_WORD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $stable(ws)) |-> bitc == nbits); // R2
endmodule

// File: tb/test_spi_reg_master.sv
module test_spi_reg_master;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, lb = 1, miso_drv = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq, sclk, mosi, miso;
  int total = 0, bad = 0;
  logic [31:0] lastm = 0;

  assign miso = lb ? mosi : miso_drv;
  always #2.5 clk = ~clk;

  spi_reg_master i_spi_reg_master (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
    .miso(miso));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input int w);
    case (w)
      0: return {old[31:8], nw[7:0]};
      1: return {old[31:16], nw[15:0]};
      2: return nw;
      default: return {old[31:9], nw[8:0]};
    endcase
  endfunction

  function automatic logic [31:0] lowbits(input logic [31:0] d, input int w, input logic v9);
    case (w)
      0: return {24'b0, d[7:0]};
      1: return {16'b0, d[15:0]};
      2: return d;
      default: return {23'b0, v9, d[7:0]};
    endcase
  endfunction

  function automatic int nbits(input int w);
    case (w) 0: return 8; 1: return 16; 2: return 32; default: return 9; endcase
  endfunction

  function automatic int period(input int c);
    case (c) 0: return 8; 1: return 4; 2: return 2; default: return 14; endcase
  endfunction

  task automatic rdchk(input string tag, input logic [31:0] low, input int w);
    logic [31:0] v, e;
    rd(4'h4, v);
    e = merge(lastm, low, w);
    chk(tag, v, e);
    lastm = e;
  endtask

  task automatic xfer(input logic [31:0] d, output logic [31:0] got, output int bc,
                      output int tg);
    logic prev;
    wr(4'h4, d);
    addr = 4'h0; bc = 0; tg = 0; prev = sclk;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (rdata[19]) bc++;
      if (sclk !== prev) tg++;
      prev = sclk;
      if (!rdata[19] && bc > 0) break;
    end
    rd(4'h4, got);
  endtask

  initial begin
    #750000;
    total++; bad++;
    $display("FAIL watchdog R1 act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, got, e;
    int bc, tg, seed;
    seed = $urandom(32'd2024);
    idle(3); rst_n = 1; idle(1);

    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl reset", v, 32'h00A30000);
    chk("R1 irq reset", irq, 0); chk("R5 sclk reset", sclk, 0); chk("R10 mosi reset", mosi, 0);
    wr(4'h0, 32'h00E8_3800); rd(4'h0, v);
    chk("R1 status bits ignore writes", v & 32'h00E8_3800, 32'h00A0_0000);

    // R13 input delay
    lb = 0; miso_drv = 0; idle(3);
    @(negedge clk); miso_drv = 1; addr = 4'h0;
    @(negedge clk); chk("R13 one clock", rdata[12], 0);
    @(negedge clk); chk("R13 two clocks", rdata[12], 1);
    lb = 1;

    // R10 idle level
    wr(4'h0, 32'h31); idle(1); chk("R10 idle high", mosi, 1);
    wr(4'h0, 32'h11); idle(1); chk("R10 idle low", mosi, 0);

    // R2 R3 R4 R5 R6 random formats
    for (int i = 0; i < 24; i++) begin
      int w, c; logic pl, pa, v9, mi; logic [31:0] d;
      w = $urandom % 4; c = $urandom % 4; pl = $urandom % 2; pa = $urandom % 2;
      v9 = $urandom % 2; mi = $urandom % 2; d = $urandom;
      wr(4'h0, 32'h1 | 32'(pa) << 1 | 32'(pl) << 2 | 32'(c) << 3 | 32'(w) << 8 |
               32'(mi) << 14 | 32'(v9) << 20);
      @(negedge clk); chk("R5 sclk idle level", sclk, pl);
      xfer(d, got, bc, tg);
      e = merge(lastm, lowbits(d, w, v9), w);
      chk("R2 R3 looped word", got, e); lastm = e;
      chk("R4 busy cycles", bc, nbits(w) * period(c));
      chk("R5 clock transitions", tg, 2 * nbits(w));
      rd(4'h0, v); chk("R6 flag set", v[13], 1); chk("R6 irq mask", irq, mi);
      rd(4'h8, v); chk("R6 clear reads 0", v, 0);
      wr(4'h8, 32'h0); rd(4'h0, v); chk("R6 flag cleared", v[13], 0);
    end

    // R3 directed lead bit
    wr(4'h0, 32'h0010_0311);
    xfer(32'h0, got, bc, tg);
    e = merge(lastm, 32'h100, 3); chk("R3 lead bit", got, e); lastm = e;
    rd(4'h4, v); chk("R2 empty read keeps value", v, lastm);

    // R7 R8 mode 0 fill and stall
    wr(4'h0, 32'h11);
    for (int k = 0; k < 4; k++) wr(4'h4, 32'hA0 + k);
    idle(150);
    rd(4'h0, v); chk("R8 rx full", v[22], 1); chk("R7 tx empty", v[23], 1);
    for (int k = 0; k < 5; k++) wr(4'h4, 32'hB0 + k);
    idle(60);
    rd(4'h0, v);
    chk("R8 busy low in stall", v[19], 0); chk("R8 tx kept", v[23], 0);
    chk("R7 tx full", v[11], 1);
    for (int k = 0; k < 4; k++) rdchk("R7 order first", 32'hA0 + k, 0);
    idle(150);
    for (int k = 0; k < 4; k++) rdchk("R8 resumed order", 32'hB0 + k, 0);
    rd(4'h0, v); chk("R7 full write dropped", v[21], 1);

    // R9 mode 2
    wr(4'h0, 32'h20011);
    for (int k = 0; k < 3; k++) wr(4'h4, 32'hC0 + k);
    idle(120);
    rdchk("R9 mode2 newest kept", 32'hC2, 0);
    rd(4'h0, v); chk("R9 mode2 one entry", v[21], 1);

    // R9 mode 1
    wr(4'h0, 32'h10011);
    for (int k = 0; k < 4; k++) begin wr(4'h4, 32'hD0 + k); idle(30); end
    wr(4'h4, 32'h5A); wr(4'h4, 32'h5B);
    rd(4'h0, v); chk("R9 mode1 tx full", v[11], 1);
    for (int k = 0; k < 4; k++) rdchk("R9 mode1 rx", 32'hD0 + k, 0);
    idle(40);
    rdchk("R9 mode1 overwrite", 32'h5B, 0);
    rd(4'h0, v); chk("R9 mode1 only one", v[21], 1);

    // R9 mode 3
    wr(4'h0, 32'h30011);
    wr(4'h4, 32'h61); idle(30);
    wr(4'h4, 32'h62); idle(30);
    rd(4'h0, v);
    chk("R9 mode3 tx full", v[11], 1); chk("R8 mode3 stalled", v[19], 0);
    wr(4'h4, 32'h63);
    rdchk("R9 mode3 first", 32'h61, 0); idle(30);
    rdchk("R9 mode3 second", 32'h62, 0);
    rd(4'h0, v); chk("R9 mode3 third dropped", v[21], 1);

    // R10 force
    wr(4'h0, 32'h431);
    xfer(32'h0, got, bc, tg);
    e = merge(lastm, 32'hFF, 0); chk("R10 forced level", got, e); lastm = e;

    // R11 drain
    wr(4'h0, 32'h219);
    wr(4'h4, 32'h1234_5678); wr(4'h4, 32'h9ABC_DEF0);
    wr(4'h0, 32'h218);
    addr = 4'h0; bc = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (rdata[19]) bc++;
      if (!rdata[19] && rdata[23]) break;
    end
    chk("R11 drain busy cycles", bc, 892);
    idle(2); rd(4'h0, v);
    chk("R11 rx cleared", v[21], 1); chk("R11 flag cleared", v[13], 0);
    lastm = 0;
    rd(4'h4, v); chk("R11 read value cleared", v, 0);
    wr(4'h4, 32'h77); rd(4'h0, v);
    chk("R11 write while off dropped", v[23], 1);

    // R12 soft reset
    wr(4'h0, 32'h4011); wr(4'h4, 32'h3C); idle(40);
    chk("R6 irq raised", irq, 1);
    wr(4'h0, 32'h4091); idle(2); rd(4'h0, v);
    chk("R12 flag cleared", v[13], 0); chk("R12 rx cleared", v[21], 1);
    chk("R12 irq low", irq, 0);
    wr(4'h4, 32'h3D); rd(4'h0, v); chk("R12 write dropped", v[23], 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule